// File: doc/BRIEF.md
# Multichannel Phase-Offset PWM Generator

A bank of pulse-width-modulated outputs that all run from one shared period counter. The counter advances one step per tick, and ticks come from a programmable divider on the input clock. Each channel holds a start position and a stop position on that counter. Its output rises at the start position and falls at the stop position, so both the phase and the width of each pulse can be set. When the stop position is below the start position, the high window wraps across the end of the period.

Two flag bits bypass the position compare: a constant-high flag in the start word and a constant-low flag in the stop word. The constant-high flag wins when both flags are set. A mode register holds a sleep bit and a global polarity-invert bit. Sleep freezes the divider and the counter. The divider ratio can only be rewritten while the block is asleep.

Channel words and the divider value arrive on parallel inputs, each with its own write strobe. New channel words are held in a staging copy and take effect together when the counter wraps to zero, so a change made in mid-period never cuts a pulse short.

Top module: `phase_pwm_bank`

## Requirements
- R1: After reset, every output is low, `count_o` is 0, the sleep bit is set (the counter stays at 0), the divider value is 30 and every channel is constant-low.
- R2: With sleep clear, `count_o` advances by one every PRE+1 clock cycles and wraps from 2**CNT_W-1 (4095 by default) to 0.
- R3: A divider write (`pre_we_i`) takes effect only when sleep is set and the value is in the range 3 to 255. Any other divider write is ignored.
- R4: While sleep is set, `count_o` and all outputs hold their values.
- R5: Bit CNT_W (bit 12 by default) of a start word is the constant-high flag. When it is set, the output is high, whatever the stop word holds.
- R6: Bit CNT_W of a stop word is the constant-low flag. When it is set and the constant-high flag is clear, the output is low.
- R7: With no flags and start < stop, the output is high for counts start through stop-1 and low otherwise.
- R8: With no flags and stop < start, the output is high for counts >= start or < stop (the window wraps).
- R9: With no flags and start == stop, the output is low for the whole period.
- R10: A channel write (`cfg_we_i`, channel `cfg_ch_i`) changes that channel's output only from the tick where the counter wraps to 0. Until then the previous words stay in force.
- R11: A set invert bit (written together with sleep through `mode_we_i`) inverts every output.
- R12: Each output is registered. It reflects the counter value and mode of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we_i | input | 1 | Writes the sleep and invert bits |
| sleep_i | input | 1 | Sleep value for a mode write |
| invert_i | input | 1 | Invert value for a mode write |
| pre_we_i | input | 1 | Divider write strobe |
| pre_val_i | input | PRE_W | Divider value (tick = clk / (value+1)) |
| cfg_we_i | input | 1 | Channel word write strobe |
| cfg_ch_i | input | CH_W | Channel index for the write |
| cfg_on_i | input | CNT_W+1 | Start word: position, plus constant-high flag at bit CNT_W |
| cfg_off_i | input | CNT_W+1 | Stop word: position, plus constant-low flag at bit CNT_W |
| pwm_o | output | NUM_CH | Registered PWM outputs |
| count_o | output | CNT_W | Shared period counter |

## Verification
The bench builds the bank with NUM_CH=4 and CNT_W=8. A period is then 256 ticks, or 1024 clocks at the smallest divider, so many full periods, wrap-time reloads and mid-period rewrites fit in a short run. The divider width stays at its default of 8 bits, which keeps both range limits (3 and 255) and the reset ratio of 30 reachable. Four channels are enough to hold a plain window, a wrapped window, an empty window and a flag-controlled channel at the same time, while a scoreboard follows every output on every cycle.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

  // Window class of a channel, decided once per period when the staged words
  // are promoted, so the per-cycle compare only has to evaluate one form.
  typedef enum logic [2:0] {
    WK_FULL_OFF  = 3'd0,
    WK_FULL_ON   = 3'd1,
    WK_EMPTY     = 3'd2,
    WK_RISE_FALL = 3'd3,
    WK_WRAPPED   = 3'd4
  } win_kind_e;

  // The constant-high flag is tested first, so it wins over constant-low.
  function automatic win_kind_e classify(input logic hi_flag, input logic lo_flag,
                                         input logic pos_eq, input logic pos_lt);
    if (hi_flag)      return WK_FULL_ON;
    else if (lo_flag) return WK_FULL_OFF;
    else if (pos_eq)  return WK_EMPTY;
    else if (pos_lt)  return WK_RISE_FALL;
    else              return WK_WRAPPED;
  endfunction

endpackage

// File: rtl/pwmb_prescaler.sv
module pwmb_prescaler #(
  parameter int PRE_W   = 8,
  parameter int PRE_MIN = 3,
  parameter int PRE_MAX = 255,
  parameter int PRE_RST = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             pre_we_i,
  input  logic [PRE_W-1:0] pre_val_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] pre_q_o
);

  logic [PRE_W-1:0] div_q;
  logic             accept;

  // A new ratio is taken only while asleep and only inside the legal range.
  assign accept = sleep_i && pre_we_i &&
                  (int'(pre_val_i) >= PRE_MIN) && (int'(pre_val_i) <= PRE_MAX);

  assign tick_o = !sleep_i && (div_q == pre_q_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q_o <= PRE_W'(PRE_RST);
      div_q   <= '0;
    end else begin
      if (accept) begin
        pre_q_o <= pre_val_i;
        div_q   <= '0;
      end else if (!sleep_i) begin
        if (div_q == pre_q_o) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwmb_period_counter.sv
module pwmb_period_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);

  // wrap_o marks the edge on which the count goes from its top value to 0.
  assign wrap_o = tick_i && (&count_o);

  always_ff @(posedge clk) begin
    if (rst)         count_o <= '0;
    else if (tick_i) count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/pwmb_channel.sv
module pwmb_channel
  import pwmb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W:0]   on_word_i,
  input  logic [CNT_W:0]   off_word_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             invert_i,
  output logic             pwm_o,
  output logic             full_on_o
);

  localparam int FLAG_BIT = CNT_W;

  logic [CNT_W:0]   stage_on_q, stage_off_q;
  logic [CNT_W-1:0] rise_q, fall_q;
  win_kind_e        kind_q, kind_d;
  logic             level;

  // Staging copy: written at any time, read only at the period boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_on_q  <= '0;
      stage_off_q <= {1'b1, {CNT_W{1'b0}}};
    end else if (load_i) begin
      stage_on_q  <= on_word_i;
      stage_off_q <= off_word_i;
    end
  end

  always_comb begin
    kind_d = classify(stage_on_q[FLAG_BIT], stage_off_q[FLAG_BIT],
                      stage_on_q[CNT_W-1:0] == stage_off_q[CNT_W-1:0],
                      stage_on_q[CNT_W-1:0] <  stage_off_q[CNT_W-1:0]);
  end

  // Active copy: promoted as the counter wraps to 0, so no pulse is cut.
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= WK_FULL_OFF;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wrap_i) begin
      kind_q <= kind_d;
      rise_q <= stage_on_q[CNT_W-1:0];
      fall_q <= stage_off_q[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (kind_q)
      WK_FULL_ON:   level = 1'b1;
      WK_RISE_FALL: level = (count_i >= rise_q) && (count_i < fall_q);
      WK_WRAPPED:   level = (count_i >= rise_q) || (count_i < fall_q);
      default:      level = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= level ^ invert_i;
  end

  assign full_on_o = (kind_q == WK_FULL_ON);

endmodule

// File: rtl/phase_pwm_bank.sv
module phase_pwm_bank #(
  parameter int NUM_CH  = 16,
  parameter int CNT_W   = 12,
  parameter int PRE_W   = 8,
  parameter int PRE_MIN = 3,
  parameter int PRE_MAX = 255,
  parameter int PRE_RST = 30,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we_i,
  input  logic              sleep_i,
  input  logic              invert_i,
  input  logic              pre_we_i,
  input  logic [PRE_W-1:0]  pre_val_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [CNT_W:0]    cfg_on_i,
  input  logic [CNT_W:0]    cfg_off_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [CNT_W-1:0]  count_o
);

  logic              sleep_q, invert_q;
  logic              tick, wrap;
  logic [PRE_W-1:0]  pre_q;
  logic [NUM_CH-1:0] full_on_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q  <= 1'b1;
      invert_q <= 1'b0;
    end else if (mode_we_i) begin
      sleep_q  <= sleep_i;
      invert_q <= invert_i;
    end
  end

  pwmb_prescaler #(
    .PRE_W(PRE_W), .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX), .PRE_RST(PRE_RST)
  ) u_pre (
    .clk(clk), .rst(rst), .sleep_i(sleep_q), .pre_we_i(pre_we_i),
    .pre_val_i(pre_val_i), .tick_o(tick), .pre_q_o(pre_q)
  );

  pwmb_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .count_o(count_o), .wrap_o(wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = cfg_we_i && (int'(cfg_ch_i) == g);
    pwmb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .load_i(sel),
      .on_word_i(cfg_on_i), .off_word_i(cfg_off_i),
      .wrap_i(wrap), .count_i(count_o), .invert_i(invert_q),
      .pwm_o(pwm_o[g]), .full_on_o(full_on_vec[g])
    );
  end

endmodule

// File: rtl/phase_pwm_bank_chk.sv
module phase_pwm_bank_chk #(
  parameter int NUM_CH  = 16,
  parameter int CNT_W   = 12,
  parameter int PRE_W   = 8,
  parameter int PRE_MIN = 3,
  parameter int PRE_MAX = 255
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_q,
  input logic              invert_q,
  input logic [PRE_W-1:0]  pre_q,
  input logic [NUM_CH-1:0] full_on,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [CNT_W-1:0]  count_o
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pwm_o == '0) && (count_o == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1));

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(pre_q) >= PRE_MIN) && (int'(pre_q) <= PRE_MAX));

  // R3
  pre_awake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_q |=> $stable(pre_q));

  // R4
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_q |=> $stable(count_o));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R5
    full_on_high_chk: assert property (@(posedge clk) disable iff (rst)
      (full_on[i] && !invert_q) |=> pwm_o[i]);
    // R11
    full_on_inv_chk: assert property (@(posedge clk) disable iff (rst)
      (full_on[i] && invert_q) |=> !pwm_o[i]);
  end

endmodule

bind phase_pwm_bank phase_pwm_bank_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .sleep_q(sleep_q), .invert_q(invert_q), .pre_q(pre_q),
  .full_on(full_on_vec), .pwm_o(pwm_o), .count_o(count_o)
);

// File: tb/phase_pwm_bank_tb.sv
module phase_pwm_bank_tb;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int PW   = 8;
  localparam int CHW  = 2;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           mode_we = 0, sleep_v = 0, inv_v = 0, pre_we = 0, cfg_we = 0;
  logic [PW-1:0]  pre_val = '0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [CW:0]    cfg_on = '0, cfg_off = '0;
  logic [NCH-1:0] pwm_o;
  logic [CW-1:0]  count_o;

  phase_pwm_bank #(.NUM_CH(NCH), .CNT_W(CW), .PRE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .mode_we_i(mode_we), .sleep_i(sleep_v), .invert_i(inv_v),
    .pre_we_i(pre_we), .pre_val_i(pre_val), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_on_i(cfg_on), .cfg_off_i(cfg_off), .pwm_o(pwm_o), .count_o(count_o)
  );

  int n_tests = 0, n_fail = 0;
  string tag = "R1";

  // Reference model state
  logic [CW:0]    sh_on[NCH], sh_off[NCH], ac_on[NCH], ac_off[NCH];
  logic           inv_m = 1'b0;
  logic [NCH-1:0] expq[$];
  int             prev_cnt = 0;
  bit             mon_en = 0;

  initial for (int i = 0; i < NCH; i++) begin
    sh_on[i] = '0; sh_off[i] = {1'b1, {CW{1'b0}}};
    ac_on[i] = '0; ac_off[i] = {1'b1, {CW{1'b0}}};
  end

  function automatic logic lvl(logic [CW:0] on, logic [CW:0] off, int c);
    int a = int'(on[CW-1:0]);
    int b = int'(off[CW-1:0]);
    if (on[CW])  return 1'b1;   // R5
    if (off[CW]) return 1'b0;   // R6
    if (a == b)  return 1'b0;   // R9
    if (a < b)   return (c >= a) && (c < b);  // R7
    return (c >= a) || (c < b);               // R8
  endfunction

  task automatic check(string t, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  // Monitor / scoreboard: one expected vector per cycle, compared one cycle later (R12).
  always @(negedge clk) begin
    logic [NCH-1:0] e;
    int c;
    if (mon_en) begin
      c = int'(count_o);
      if (prev_cnt == MAXC && c == 0)  // R10 promotion at wrap
        for (int i = 0; i < NCH; i++) begin ac_on[i] = sh_on[i]; ac_off[i] = sh_off[i]; end
      if (expq.size() > 0) begin
        e = expq.pop_front();
        check({tag, " R12 scoreboard"}, int'(pwm_o), int'(e));
      end
      e = '0;
      for (int i = 0; i < NCH; i++) e[i] = lvl(ac_on[i], ac_off[i], c) ^ inv_m;
      expq.push_back(e);
      prev_cnt = c;
    end
  end

  task automatic set_mode(bit slp, bit inv);
    @(negedge clk); mode_we = 1; sleep_v = slp; inv_v = inv;
    @(posedge clk); #1; mode_we = 0; inv_m = inv;
  endtask

  task automatic set_pre(int v);
    @(negedge clk); pre_we = 1; pre_val = PW'(v);
    @(posedge clk); #1; pre_we = 0;
  endtask

  task automatic cfg(int ch, logic [CW:0] on, logic [CW:0] off);
    do @(negedge clk); while (int'(count_o) == MAXC);
    cfg_we = 1; cfg_ch = CHW'(ch); cfg_on = on; cfg_off = off;
    @(posedge clk); #1; cfg_we = 0; sh_on[ch] = on; sh_off[ch] = off;
  endtask

  task automatic meas(int exp, string t);
    int c0, n;
    @(negedge clk); c0 = int'(count_o);
    while (int'(count_o) == c0) @(negedge clk);
    c0 = int'(count_o); n = 0;
    while (int'(count_o) == c0) begin @(negedge clk); n++; end
    check(t, n, exp);
  endtask

  task automatic wait_cnt(int x);
    do @(negedge clk); while (int'(count_o) != x);
    @(negedge clk);
  endtask

  task automatic wait_wrap();
    wait_cnt(MAXC);
    wait_cnt(0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c;
    logic [NCH-1:0] snap;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0; mon_en = 1;
    check("R1 outputs low", int'(pwm_o), 0);
    check("R1 count zero", int'(count_o), 0);
    repeat (40) @(negedge clk);
    check("R1 asleep after reset, count held", int'(count_o), 0);

    tag = "R2";
    set_mode(0, 0);
    meas(31, "R1 reset divider 30 -> 31 clocks per tick");
    set_mode(1, 0);
    set_pre(3);
    set_mode(0, 0);
    meas(4, "R2 divider 3 -> 4 clocks per tick");
    set_pre(9);
    meas(4, "R3 divider write while awake ignored");

    tag = "R5/R6/R7/R8/R9";
    cfg(0, {1'b0, 8'd10},  {1'b0, 8'd100});
    cfg(1, {1'b0, 8'd200}, {1'b0, 8'd50});
    cfg(2, {1'b0, 8'd70},  {1'b0, 8'd70});
    cfg(3, {1'b1, 8'd5},   {1'b1, 8'd9});
    repeat (2) @(negedge clk);
    check("R10 outputs unchanged before wrap", int'(pwm_o), 0);
    wait_wrap();
    wait_cnt(20);  check("R7 R8 R9 R5 at count 20", int'(pwm_o), 4'b1011);
    wait_cnt(120); check("R7 R8 at count 120", int'(pwm_o), 4'b1000);
    wait_cnt(220); check("R8 wrapped window at 220", int'(pwm_o), 4'b1010);

    tag = "R11";
    set_mode(0, 1);
    wait_cnt(20); check("R11 inverted at count 20", int'(pwm_o), 4'b0100);
    set_mode(0, 0);

    tag = "R10";
    wait_cnt(30);
    cfg(0, {1'b0, 8'd128}, {1'b0, 8'd200});
    cfg(2, {1'b0, 8'd5},   {1'b1, 8'd100});
    wait_cnt(60); check("R10 old words hold until wrap", int'(pwm_o[0]), 1);
    wait_wrap();
    wait_cnt(60);  check("R10 new window low at 60", int'(pwm_o[0]), 0);
    wait_cnt(150); check("R10 new window high at 150", int'(pwm_o[0]), 1);
    check("R6 constant-low flag", int'(pwm_o[2]), 0);

    tag = "R4";
    set_mode(1, 0);
    @(negedge clk); c = int'(count_o); snap = pwm_o;
    repeat (30) @(negedge clk);
    check("R4 count frozen in sleep", int'(count_o), c);
    check("R4 outputs held in sleep", int'(pwm_o), int'(snap));

    tag = "R3";
    set_pre(2);
    set_mode(0, 0);
    meas(4, "R3 divider below minimum ignored");
    set_mode(1, 0);
    set_pre(5);
    set_mode(0, 0);
    meas(6, "R3 divider 5 accepted while asleep");
    wait_wrap();
    repeat (20) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule